// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block holds a running time of day split into a seconds count and a sub-second count. On every enabled clock the sub-second count grows by a programmable step. When it passes its wrap limit it folds back and carries one into the seconds count. The wrap limit is chosen by a mode input. In decimal mode the limit is one billion, so one unit is one nanosecond. In binary mode the limit is 2^31-1, so one unit is a little under half a nanosecond.

There are two ways to advance the count. Coarse mode applies the step on every enabled clock. Fine mode runs a phase accumulator that adds an addend on each enabled clock, and it applies the step only on clocks where the accumulator carries out. Fine mode therefore gives fractional rates.

Software can correct the time with a signed offset. The offset is added to or subtracted from both fields at once, with carry or borrow between them. Software can also initialize the time to zero or to given values in one cycle, and it can freeze the count with an enable input. The live seconds and sub-second values are outputs for capture and compare logic placed downstream.

Top module: `tod_counter`

## Requirements
- R1: While rst_n is low, both time fields and the fine accumulator clear to zero.
- R2: In coarse mode (coarse_sel=1), each clock with enable=1 adds step to the sub-second field. The step must not exceed the active wrap limit.
- R3: In decimal mode (wrap_mode=0), the sub-second field takes values from 0 to 999,999,999. A sum of 1,000,000,000 or more wraps by subtracting 1,000,000,000 and adds one to seconds.
- R4: In binary mode (wrap_mode=1), the sub-second field takes values from 0 to 0x7FFFFFFE. A sum of 0x7FFFFFFF or more wraps by subtracting 0x7FFFFFFF and adds one to seconds.
- R5: In fine mode (coarse_sel=0), a 32-bit accumulator adds fine_addend on each enabled clock. The step is applied only on a clock where that addition carries out of bit 31.
- R6: With enable=0 and no update or initialize request, the seconds field, the sub-second field and the accumulator all hold their values.
- R7: An accepted update with upd_sub=0 adds (upd_sec, upd_subsec) to the time. The carry from the sub-second field goes into seconds. The update applies on top of that clock's normal advance.
- R8: An accepted update with upd_sub=1 subtracts (upd_sec, upd_subsec). A sub-second underflow adds the wrap limit back and borrows one second.
- R9: An update whose upd_subsec exceeds the active wrap limit is ignored, and the time advances as if no update had been requested. A value equal to the limit is accepted and counts as one second.
- R10: An initialize request with init_load=0 sets both fields to zero and clears the accumulator in one cycle. It takes priority over the advance and over any update in the same cycle.
- R11: An initialize request with init_load=1 loads init_sec and init_subsec when init_subsec is below the active wrap limit. Otherwise the request is ignored and the clock behaves as if no initialize request were present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Counting enable |
| wrap_mode | input | 1 | 0 = decimal wrap at 10^9, 1 = binary wrap at 2^31-1 |
| coarse_sel | input | 1 | 1 = step every enabled clock, 0 = step on accumulator carry |
| step | input | SUB_W | Sub-second increment |
| fine_addend | input | ACC_W | Accumulator addend for fine mode |
| upd_valid | input | 1 | Offset correction request |
| upd_sub | input | 1 | 0 = add offset, 1 = subtract offset |
| upd_sec | input | SEC_W | Seconds part of the offset |
| upd_subsec | input | SUB_W | Sub-second part of the offset |
| init_valid | input | 1 | Initialize request |
| init_load | input | 1 | 0 = load zero, 1 = load given values |
| init_sec | input | SEC_W | Seconds value to load |
| init_subsec | input | SUB_W | Sub-second value to load |
| tod_sec | output | SEC_W | Live seconds count |
| tod_subsec | output | SUB_W | Live sub-second count |

## Verification
The bench builds the block with its default widths: 32-bit seconds, a 31-bit sub-second field and a 32-bit accumulator, with the decimal limit at one billion. Steps of hundreds of millions, together with start values placed just below either limit, make a wrap happen within one or two clocks in both modes. An addend of 2^30 gives an accumulator carry on every fourth clock, so the fine-mode step rate can be checked exactly in a short window. Long runs with pseudo-random enables, steps, addends and add-only corrections are compared against a model that keeps the time as a single total count.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int unsigned TOD_DEC_WRAP = 1_000_000_000;

    typedef enum logic {
        WRAP_DEC = 1'b0,
        WRAP_BIN = 1'b1
    } wrap_mode_e;

    typedef enum logic {
        OFS_ADD = 1'b0,
        OFS_SUB = 1'b1
    } ofs_dir_e;

endpackage

// File: rtl/tod_rate_gen.sv
module tod_rate_gen #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fine_mode,
    input  logic             clear,
    input  logic [ACC_W-1:0] addend,
    output logic             tick
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } rate_st_t;

    rate_st_t    st_d, st_q;
    logic [ACC_W:0] acc_sum;

    always_comb begin
        st_d    = st_q;
        tick    = 1'b0;
        acc_sum = {1'b0, st_q.acc} + {1'b0, addend};
        if (clear) begin
            st_d.acc = '0;
        end else if (run) begin
            if (fine_mode) begin
                st_d.acc = acc_sum[ACC_W-1:0];
                tick     = acc_sum[ACC_W];
            end else begin
                tick = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: accumulator frozen while not running
    assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(st_q.acc));

    // R5: a fine-mode step happens only when the accumulator wrapped below its old value
    assert_fine_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fine_mode && !clear && tick) |=> (st_q.acc < $past(st_q.acc) || $past(addend) == '0 || $past(st_q.acc) == st_q.acc));

endmodule

// File: rtl/tod_wrap_add.sv
module tod_wrap_add #(
    parameter int SEC_W = 32,
    parameter int SUB_W = 31
) (
    input  logic [SEC_W-1:0] base_sec,
    input  logic [SUB_W-1:0] base_sub,
    input  logic [SEC_W-1:0] delta_sec,
    input  logic [SUB_W-1:0] delta_sub,
    input  logic             subtract,
    input  logic [SUB_W-1:0] limit,
    output logic [SEC_W-1:0] res_sec,
    output logic [SUB_W-1:0] res_sub
);

    logic [SUB_W:0] sum_w;
    logic [SUB_W:0] lend_w;
    logic           spill;

    always_comb begin
        sum_w  = {1'b0, base_sub} + {1'b0, delta_sub};
        lend_w = {1'b0, base_sub} + {1'b0, limit} - {1'b0, delta_sub};
        spill  = 1'b0;
        if (!subtract) begin
            if (sum_w >= {1'b0, limit}) begin
                res_sub = SUB_W'(sum_w - {1'b0, limit});
                spill   = 1'b1;
            end else begin
                res_sub = sum_w[SUB_W-1:0];
            end
            res_sec = base_sec + delta_sec + {{(SEC_W-1){1'b0}}, spill};
        end else begin
            if (base_sub >= delta_sub) begin
                res_sub = base_sub - delta_sub;
            end else begin
                res_sub = lend_w[SUB_W-1:0];
                spill   = 1'b1;
            end
            res_sec = base_sec - delta_sec - {{(SEC_W-1){1'b0}}, spill};
        end
    end

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
#(
    parameter int          SEC_W    = 32,
    parameter int          SUB_W    = 31,
    parameter int          ACC_W    = 32,
    parameter int unsigned DEC_WRAP = TOD_DEC_WRAP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wrap_mode,
    input  logic             coarse_sel,
    input  logic [SUB_W-1:0] step,
    input  logic [ACC_W-1:0] fine_addend,
    input  logic             upd_valid,
    input  logic             upd_sub,
    input  logic [SEC_W-1:0] upd_sec,
    input  logic [SUB_W-1:0] upd_subsec,
    input  logic             init_valid,
    input  logic             init_load,
    input  logic [SEC_W-1:0] init_sec,
    input  logic [SUB_W-1:0] init_subsec,
    output logic [SEC_W-1:0] tod_sec,
    output logic [SUB_W-1:0] tod_subsec
);

    localparam logic [SUB_W-1:0] DEC_LIM = SUB_W'(DEC_WRAP);
    localparam logic [SUB_W-1:0] BIN_LIM = {SUB_W{1'b1}};

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } tod_t;

    tod_t             tod_d, tod_q;
    wrap_mode_e       mode_w;
    ofs_dir_e         dir_w;
    logic [SUB_W-1:0] limit_w;
    logic             init_ok;
    logic             upd_ok;
    logic             adv_tick;
    logic [SEC_W-1:0] adv_sec, cor_sec;
    logic [SUB_W-1:0] adv_sub, cor_sub;

    assign mode_w  = wrap_mode_e'(wrap_mode);
    assign dir_w   = ofs_dir_e'(upd_sub);
    assign limit_w = (mode_w == WRAP_BIN) ? BIN_LIM : DEC_LIM;
    assign init_ok = init_valid && (!init_load || (init_subsec < limit_w));
    assign upd_ok  = upd_valid && (upd_subsec <= limit_w);

    tod_rate_gen #(.ACC_W(ACC_W)) rate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (enable),
        .fine_mode (!coarse_sel),
        .clear     (init_ok),
        .addend    (fine_addend),
        .tick      (adv_tick)
    );

    // stage 1: normal advance by the step
    tod_wrap_add #(.SEC_W(SEC_W), .SUB_W(SUB_W)) adv_i (
        .base_sec  (tod_q.sec),
        .base_sub  (tod_q.sub),
        .delta_sec ('0),
        .delta_sub (adv_tick ? step : '0),
        .subtract  (1'b0),
        .limit     (limit_w),
        .res_sec   (adv_sec),
        .res_sub   (adv_sub)
    );

    // stage 2: signed offset correction on the advanced value
    tod_wrap_add #(.SEC_W(SEC_W), .SUB_W(SUB_W)) cor_i (
        .base_sec  (adv_sec),
        .base_sub  (adv_sub),
        .delta_sec (upd_ok ? upd_sec : '0),
        .delta_sub (upd_ok ? upd_subsec : '0),
        .subtract  (upd_ok && (dir_w == OFS_SUB)),
        .limit     (limit_w),
        .res_sec   (cor_sec),
        .res_sub   (cor_sub)
    );

    always_comb begin
        tod_d = tod_q;
        if (init_ok) begin
            if (init_load) begin
                tod_d.sec = init_sec;
                tod_d.sub = init_subsec;
            end else begin
                tod_d = '0;
            end
        end else begin
            tod_d.sec = cor_sec;
            tod_d.sub = cor_sub;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tod_q <= '0;
        else        tod_q <= tod_d;
    end

    assign tod_sec    = tod_q.sec;
    assign tod_subsec = tod_q.sub;

    // R3: decimal field stays below one billion while the mode is steady
    assert_dec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_mode == 1'b0 && $past(wrap_mode) == 1'b0 && $past(tod_q.sub) < DEC_LIM
         && $past(step) <= DEC_LIM) |-> (tod_q.sub < DEC_LIM));

    // R4: binary field never reaches the all-ones value while the mode is steady
    assert_bin_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_mode == 1'b1 && $past(wrap_mode) == 1'b1) |-> (tod_q.sub != BIN_LIM));

    // R6: frozen time with no request
    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !upd_valid && !init_valid) |=> ($stable(tod_q.sec) && $stable(tod_q.sub)));

    // R9: oversize decimal correction leaves a frozen time alone
    assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !init_valid && !enable && wrap_mode == 1'b0 && upd_subsec > DEC_LIM)
        |=> ($stable(tod_q.sec) && $stable(tod_q.sub)));

    // R10: zero initialize wins over everything
    assert_init_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (init_valid && !init_load) |=> (tod_sec == '0 && tod_subsec == '0));

endmodule

// File: tb/tod_counter_tb_top.sv
module tod_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wrap_mode = 1'b0;
    logic        coarse_sel = 1'b1;
    logic [30:0] step = '0;
    logic [31:0] fine_addend = '0;
    logic        upd_valid = 1'b0;
    logic        upd_sub = 1'b0;
    logic [31:0] upd_sec = '0;
    logic [30:0] upd_subsec = '0;
    logic        init_valid = 1'b0;
    logic        init_load = 1'b0;
    logic [31:0] init_sec = '0;
    logic [30:0] init_subsec = '0;
    logic [31:0] tod_sec;
    logic [30:0] tod_subsec;

    always #2 clk = ~clk;

    tod_counter dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wrap_mode(wrap_mode),
        .coarse_sel(coarse_sel), .step(step), .fine_addend(fine_addend),
        .upd_valid(upd_valid), .upd_sub(upd_sub), .upd_sec(upd_sec),
        .upd_subsec(upd_subsec), .init_valid(init_valid), .init_load(init_load),
        .init_sec(init_sec), .init_subsec(init_subsec),
        .tod_sec(tod_sec), .tod_subsec(tod_subsec)
    );

    int     n_cmp = 0;
    int     n_bad = 0;
    bit     finished = 0;
    string  phase = "R1";
    longint m_sec = 0, m_sub = 0, m_acc = 0;
    int     cycles = 0;

    // behavioural model: time kept as one total count
    always @(posedge clk) begin
        longint lim, tot, s;
        bit tk;
        lim = wrap_mode ? 64'h7FFF_FFFF : 64'd1000000000;
        if (!rst_n) begin
            m_sec = 0; m_sub = 0; m_acc = 0;
        end else if (init_valid && (!init_load || longint'(init_subsec) < lim)) begin
            m_sec = init_load ? longint'(init_sec) : 0;
            m_sub = init_load ? longint'(init_subsec) : 0;
            m_acc = 0;
        end else begin
            tot = m_sec * lim + m_sub;
            if (enable) begin
                if (coarse_sel) tk = 1;
                else begin
                    s = m_acc + longint'(fine_addend);
                    tk = (s >= 64'h1_0000_0000);
                    m_acc = s % 64'h1_0000_0000;
                end
                if (tk) tot = tot + longint'(step);
            end
            if (upd_valid && longint'(upd_subsec) <= lim) begin
                if (upd_sub) tot = tot - (longint'(upd_sec) * lim + longint'(upd_subsec));
                else         tot = tot + (longint'(upd_sec) * lim + longint'(upd_subsec));
            end
            m_sec = tot / lim;
            m_sub = tot % lim;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !finished) begin
            n_cmp++;
            if (longint'(tod_sec) != m_sec || longint'(tod_subsec) != m_sub) begin
                n_bad++;
                $display("FAIL %s model: actual %0d.%0d expected %0d.%0d", phase,
                         tod_sec, tod_subsec, m_sec, m_sub);
            end
        end
        if (cycles > 100000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint es, input longint ens);
        n_cmp++;
        if (longint'(tod_sec) != es || longint'(tod_subsec) != ens) begin
            n_bad++;
            $display("FAIL %s: actual %0d.%0d expected %0d.%0d", tag, tod_sec, tod_subsec, es, ens);
        end
    endtask

    task automatic nxt(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic do_init(input bit ld, input longint s, input longint ns);
        init_valid = 1; init_load = ld; init_sec = 32'(s); init_subsec = 31'(ns);
        nxt(1);
        init_valid = 0;
    endtask

    task automatic do_upd(input bit sb, input longint s, input longint ns);
        upd_valid = 1; upd_sub = sb; upd_sec = 32'(s); upd_subsec = 31'(ns);
        nxt(1);
        upd_valid = 0;
    endtask

    logic [31:0] lfsr = 32'hACE1_2468;
    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr ^ {lfsr[15:0], lfsr[31:16]};
    endfunction

    task automatic random_run(input bit bin, input int n);
        longint lim;
        lim = bin ? 64'h7FFF_FFFF : 64'd1000000000;
        for (int i = 0; i < n; i++) begin
            logic [31:0] r;
            r = rnd();
            enable      = (r[1:0] != 2'b00);
            coarse_sel  = r[2];
            step        = 31'(longint'(rnd()) % (lim / 3));
            fine_addend = rnd();
            upd_valid   = (r[7:4] == 4'h3);
            upd_sub     = 1'b0;
            upd_sec     = 32'(r[9:8]);
            upd_subsec  = 31'(longint'(rnd()) % (lim + 5));
            nxt(1);
        end
        upd_valid = 0; enable = 0;
    endtask

    initial begin
        nxt(3);
        phase = "R1";
        chk("R1 reset value", 0, 0);
        rst_n = 1;
        nxt(1);
        chk("R1 after release", 0, 0);

        phase = "R2"; step = 100; enable = 1;
        nxt(10); enable = 0;
        chk("R2 coarse ten steps", 0, 1000);

        phase = "R3";
        do_init(1, 5, 999_999_950);
        enable = 1; nxt(1); enable = 0;
        chk("R3 decimal wrap carry", 6, 50);

        phase = "R4"; wrap_mode = 1;
        do_init(1, 1, 64'h7FFF_FFF0);
        step = 31'h20; enable = 1; nxt(1); enable = 0;
        chk("R4 binary wrap carry", 2, 64'h11);

        phase = "R5"; wrap_mode = 0; coarse_sel = 0; fine_addend = 32'h4000_0000; step = 10;
        do_init(0, 0, 0);
        enable = 1; nxt(3);
        chk("R5 no carry yet", 0, 0);
        nxt(5); enable = 0;
        chk("R5 two carries", 0, 20);

        phase = "R6";
        enable = 1; nxt(2); enable = 0;
        nxt(5);
        chk("R6 frozen time", 0, 20);
        enable = 1; nxt(2); enable = 0;
        chk("R6 accumulator held", 0, 30);
        coarse_sel = 1; step = 100; nxt(4);
        chk("R6 coarse frozen", 0, 30);

        phase = "R7";
        do_init(1, 2, 900_000_000);
        do_upd(0, 3, 200_000_000);
        chk("R7 add with carry", 6, 100_000_000);
        enable = 1; do_upd(0, 0, 50); enable = 0;
        chk("R7 add on top of advance", 6, 100_000_150);

        phase = "R8";
        do_upd(1, 1, 300_000_000);
        chk("R8 subtract with borrow", 4, 800_000_150);

        phase = "R9";
        do_upd(1, 0, 1_000_000_001);
        chk("R9 oversize rejected", 4, 800_000_150);
        do_upd(0, 0, 1_000_000_000);
        chk("R9 limit accepted", 5, 800_000_150);
        wrap_mode = 1;
        do_init(1, 1, 0);
        do_upd(0, 0, 64'h7FFF_FFFF);
        chk("R9 binary limit accepted", 2, 0);
        wrap_mode = 0;

        phase = "R10";
        init_valid = 1; init_load = 0; upd_valid = 1; upd_sub = 0; upd_sec = 1; upd_subsec = 1;
        enable = 1;
        nxt(1);
        init_valid = 0; upd_valid = 0; enable = 0;
        chk("R10 zero wins", 0, 0);

        phase = "R11";
        step = 5; enable = 1;
        do_init(1, 7, 1_000_000_000);
        enable = 0;
        chk("R11 bad init ignored", 0, 5);
        do_init(1, 7, 999_999_999);
        chk("R11 good init", 7, 999_999_999);

        phase = "R3 random";
        do_init(0, 0, 0);
        random_run(0, 2000);
        phase = "R4 random";
        wrap_mode = 1;
        do_init(0, 0, 0);
        random_run(1, 2000);

        nxt(1);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule